// File: doc/BRIEF.md
# System Exception Control Register Block

This block is the software-visible face of a processor's system exception machinery. Through a simple word-wide register port, software can raise or drop the pending state of three core exceptions: the non-maskable interrupt, the deferred-service request and the periodic tick. It can also program the priority bytes of the configurable system handlers, switch the three fault handlers on and off, move the vector table, and request a system reset through a key-protected write.

The block does not arbitrate. The arbitration logic beside it supplies the vector number of the exception being serviced and whether that exception preempted another. It also supplies the best pending vector number, an "any external interrupt pending" flag, and per-vector active and pending bits. The block composes these into status words at the moment of each read. It drives the three locally held pending flags, the fault enables, the priority bytes and the vector table base back to the arbiter. The arbiter clears a locally held flag with a one-cycle "taken" pulse. The tick source sets the tick flag with its own pulse.

The reset request is only an output pulse; reset generation lives elsewhere.

Top module: `sec_ctrl_regs`

## Requirements
- R1: After reset the following are all zero: `pend_o`, `fault_en_o`, `prio_o`, `vtab_base_o`, `reg_rdata` and `sys_reset_req_o`.
- R2: A write to word 0 with bit 31 set makes `pend_o[0]` (non-maskable) high after that clock edge. A word-0 write with bit 31 clear leaves the flag unchanged. A pulse on `taken_i[0]` clears it.
- R3: A word-0 write with bit 28 set makes `pend_o[1]` (deferred service) high. Bit 27 clears it only when bit 28 is clear in the same write. A pulse on `taken_i[1]` clears it.
- R4: A word-0 write with bit 26 set makes `pend_o[2]` (tick) high. Bit 25 clears it only when bit 26 is clear in the same write. A `tick_evt_i` pulse sets the flag and wins over a same-cycle `taken_i[2]`; `taken_i[2]` alone clears it.
- R5: A read of word 0 returns the following fields: bits 8:0 hold the active vector number (0 when `act_valid_i` is low); bits 20:12 hold the pending vector (0 when `pend_valid_i` is low); bit 22 holds `ext_pend_i`; bits 26, 28 and 31 hold the tick, deferred-service and non-maskable pending flags; all other bits except bit 11 are 0.
- R6: Bit 11 of the word-0 read is 1 when no exception is active, or when the active exception has no preempted exception beneath it (`act_nested_i` low). Otherwise it is 0.
- R7: A write to word 1 stores the written value with bits 6:0 forced to 0. The stored value drives `vtab_base_o` and reads back from word 1.
- R8: A write to word 2 whose bits 31:16 equal 0x05FA and whose bit 2 is set raises `sys_reset_req_o` for exactly one cycle after the write edge. Any write without that key causes no request. Reads of word 2 return 0xFA050000.
- R9: A read of word 6 maps per-vector state (vector numbers 4 memory-manage, 5 bus, 6 usage, 11 supervisor call, 12 debug, 14 deferred service, 15 tick) as follows. Bits 0, 1, 3, 7, 8, 10 and 11 show `exc_active_i` of vectors 4, 5, 6, 11, 12, 14 and 15. Bits 12, 13, 14 and 15 show `exc_pend_i` of vectors 6, 4, 5 and 11. All other bits except 18:16 are 0.
- R10: Bits 16, 17 and 18 of a word-6 write are stored as the memory-manage, bus and usage fault enables. They drive `fault_en_o[0..2]` and read back in word 6. The other written bits are ignored.
- R11: Words 3, 4 and 5 each hold four 8-bit priorities, for handler vectors 4–7, 8–11 and 12–15 respectively, with the lowest vector in bits 7:0. The priority of vector v drives `prio_o[(v-4)*8 +: 8]`, and each word reads back as written.
- R12: Read data appears on `reg_rdata` after the clock edge that accepts the read and holds until the next read. Word 7 reads as 0, and writes to it change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tick_evt_i | input | 1 | Tick source pulse, sets the tick pending flag |
| taken_i | input | 3 | Arbiter clear pulses: [0] non-maskable, [1] deferred service, [2] tick |
| act_vec_i | input | 9 | Vector number of the active exception |
| act_valid_i | input | 1 | An exception is active |
| act_nested_i | input | 1 | The active exception preempted another one |
| pend_vec_i | input | 9 | Highest-priority pending vector number |
| pend_valid_i | input | 1 | A pending vector exists |
| ext_pend_i | input | 1 | Some external interrupt (vector 16 or above) is pending |
| exc_active_i | input | 16 | Active bit per system vector 0..15 |
| exc_pend_i | input | 16 | Pending bit per system vector 0..15 |
| pend_o | output | 3 | Locally held pending flags: [0] non-maskable, [1] deferred service, [2] tick |
| fault_en_o | output | 3 | Fault handler enables: [0] memory-manage, [1] bus, [2] usage |
| prio_o | output | 96 | Priority bytes of handler vectors 4..15 |
| vtab_base_o | output | 32 | Vector table base |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The block has a single-cycle response for every result. A write changes `pend_o`, `fault_en_o`, `prio_o` and `vtab_base_o` at the clock edge that accepts it. The reset request pulse is high for the one cycle after that edge and low in the next. Read data is captured at the accepting edge from the live status inputs, so `reg_rdata` reflects the inputs as they stood just before that edge.

The bench drives every input on the falling edge and holds each access for exactly one rising edge. It samples on the following falling edge, which is where each result is due. For the reset pulse it also samples one cycle later to confirm the pulse has dropped. Status inputs are set up a full half-cycle before the read that observes them.

// File: rtl/sec_regs_pkg.sv
package sec_regs_pkg;

  localparam int WORD_W = 32;

  // word indices of the register port
  localparam logic [2:0] A_CTL   = 3'd0;
  localparam logic [2:0] A_VTAB  = 3'd1;
  localparam logic [2:0] A_RST   = 3'd2;
  localparam logic [2:0] A_PRI0  = 3'd3;
  localparam logic [2:0] A_HSTAT = 3'd6;

  // control/status word bit positions
  localparam int B_NMI_SET  = 31;
  localparam int B_SV_SET   = 28;
  localparam int B_SV_CLR   = 27;
  localparam int B_TK_SET   = 26;
  localparam int B_TK_CLR   = 25;
  localparam int B_EXT_PEND = 22;
  localparam int B_BASE_RET = 11;
  localparam int F_PVEC_LSB = 12;

  // reset word
  localparam logic [15:0] RST_KEY_WR = 16'h05FA;
  localparam logic [15:0] RST_KEY_RD = 16'hFA05;
  localparam int          B_SYSRST   = 2;

  // vector numbers of the system handlers
  localparam int V_MEM = 4, V_BUS = 5, V_USE = 6, V_SVC = 11;
  localparam int V_DBG = 12, V_SV = 14, V_TK = 15;

  function automatic logic [WORD_W-1:0] vtab_clean(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:7], 7'd0};
  endfunction

  function automatic logic key_ok(input logic [WORD_W-1:0] w);
    return w[31:16] == RST_KEY_WR;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_word(
      input logic [WORD_W-1:0] act_vec, input logic act_valid, input logic nested,
      input logic [WORD_W-1:0] pend_vec, input logic pend_valid, input logic ext,
      input logic [2:0] flags);
    logic [WORD_W-1:0] w;
    w = act_valid ? act_vec : '0;
    if (pend_valid) w = w | (pend_vec << F_PVEC_LSB);
    w[B_BASE_RET] = !act_valid || !nested;
    w[B_EXT_PEND] = ext;
    w[B_TK_SET]   = flags[2];
    w[B_SV_SET]   = flags[1];
    w[B_NMI_SET]  = flags[0];
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] hstat_word(
      input logic [15:0] act, input logic [15:0] pend, input logic [2:0] en);
    logic [WORD_W-1:0] w;
    w = '0;
    w[0]  = act[V_MEM];
    w[1]  = act[V_BUS];
    w[3]  = act[V_USE];
    w[7]  = act[V_SVC];
    w[8]  = act[V_DBG];
    w[10] = act[V_SV];
    w[11] = act[V_TK];
    w[12] = pend[V_USE];
    w[13] = pend[V_MEM];
    w[14] = pend[V_BUS];
    w[15] = pend[V_SVC];
    w[18:16] = en;
    return w;
  endfunction

endpackage

// File: rtl/sec_pend_flag.sv
module sec_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  input  logic hw_clr,
  output logic flag_q
);

  logic set_any;
  logic clr_any;

  assign set_any = sw_set | hw_set;
  assign clr_any = sw_clr | hw_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_any) flag_q <= 1'b1;
    else if (clr_any) flag_q <= 1'b0;
  end

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> flag_q);
  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !set_any) |=> !flag_q);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_any && !clr_any) |=> $stable(flag_q));

endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
  import sec_regs_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int PRIO_WORDS = 3,
  parameter int PRIO_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [PRIO_WORDS*WORD_W-1:0] prio_q,
  output logic [2:0]                   fault_en_q,
  output logic [WORD_W-1:0]            vtab_q,
  output logic                         rst_req_q
);

  localparam int PRIO_PER_WORD = WORD_W / PRIO_W;

  logic wr_vtab, wr_hstat, wr_rst, rst_fire;

  assign wr_vtab  = wr_en && (wr_addr == ADDR_W'(A_VTAB));
  assign wr_hstat = wr_en && (wr_addr == ADDR_W'(A_HSTAT));
  assign wr_rst   = wr_en && (wr_addr == ADDR_W'(A_RST));
  assign rst_fire = wr_rst && key_ok(wr_data) && wr_data[B_SYSRST];

  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(int'(A_PRI0) + k));
    for (genvar b = 0; b < PRIO_PER_WORD; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)   prio_q[k*WORD_W + b*PRIO_W +: PRIO_W] <= '0;
        else if (hit) prio_q[k*WORD_W + b*PRIO_W +: PRIO_W] <= wr_data[b*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_en_q <= '0;
      vtab_q     <= '0;
      rst_req_q  <= 1'b0;
    end else begin
      if (wr_hstat) fault_en_q <= wr_data[18:16];
      if (wr_vtab)  vtab_q     <= vtab_clean(wr_data);
      rst_req_q <= rst_fire;
    end
  end

  // R8
  rst_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  // R8
  rst_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && wr_data[31:16] != 16'h05FA) |=> !rst_req_q);
  // R7
  vtab_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vtab_q[6:0] == 7'd0);
  // R10
  fault_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hstat |=> fault_en_q == $past(wr_data[18:16]));

endmodule

// File: rtl/sec_read_port.sv
module sec_read_port
  import sec_regs_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int VEC_W      = 9,
  parameter int PRIO_WORDS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [VEC_W-1:0]             act_vec,
  input  logic                         act_valid,
  input  logic                         act_nested,
  input  logic [VEC_W-1:0]             pend_vec,
  input  logic                         pend_valid,
  input  logic                         ext_pend,
  input  logic [15:0]                  exc_active,
  input  logic [15:0]                  exc_pend,
  input  logic [2:0]                   flags,
  input  logic [2:0]                   fault_en,
  input  logic [PRIO_WORDS*WORD_W-1:0] prio,
  input  logic [WORD_W-1:0]            vtab,
  output logic [WORD_W-1:0]            rdata_q
);

  logic [WORD_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADDR_W'(A_CTL):   rd_word = ctl_word(WORD_W'(act_vec), act_valid, act_nested,
                                           WORD_W'(pend_vec), pend_valid, ext_pend, flags);
      ADDR_W'(A_VTAB):  rd_word = vtab;
      ADDR_W'(A_RST):   rd_word = {RST_KEY_RD, 16'd0};
      ADDR_W'(A_HSTAT): rd_word = hstat_word(exc_active, exc_pend, fault_en);
      default: begin
        for (int k = 0; k < PRIO_WORDS; k++)
          if (rd_addr == ADDR_W'(int'(A_PRI0) + k)) rd_word = prio[k*WORD_W +: WORD_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
  // R12
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(7)) |=> rdata_q == '0);
  // R6
  base_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(A_CTL) && !act_valid) |=> rdata_q[11]);

endmodule

// File: rtl/sec_ctrl_regs.sv
module sec_ctrl_regs
  import sec_regs_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int VEC_W      = 9,
  parameter int PRIO_WORDS = 3,
  parameter int PRIO_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_en,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         tick_evt_i,
  input  logic [2:0]                   taken_i,
  input  logic [VEC_W-1:0]             act_vec_i,
  input  logic                         act_valid_i,
  input  logic                         act_nested_i,
  input  logic [VEC_W-1:0]             pend_vec_i,
  input  logic                         pend_valid_i,
  input  logic                         ext_pend_i,
  input  logic [15:0]                  exc_active_i,
  input  logic [15:0]                  exc_pend_i,
  output logic [2:0]                   pend_o,
  output logic [2:0]                   fault_en_o,
  output logic [PRIO_WORDS*WORD_W-1:0] prio_o,
  output logic [31:0]                  vtab_base_o,
  output logic                         sys_reset_req_o
);

  localparam int NFLAG = 3;

  logic wr_ctl, wr_any, rd_any;
  logic [NFLAG-1:0] sw_set, sw_clr, hw_set;

  assign wr_any = reg_en && reg_we;
  assign rd_any = reg_en && !reg_we;
  assign wr_ctl = wr_any && (reg_addr == ADDR_W'(A_CTL));

  // flag 0: non-maskable (no software clear), 1: deferred service, 2: tick
  assign sw_set = {wr_ctl && reg_wdata[B_TK_SET], wr_ctl && reg_wdata[B_SV_SET],
                   wr_ctl && reg_wdata[B_NMI_SET]};
  assign sw_clr = {wr_ctl && reg_wdata[B_TK_CLR], wr_ctl && reg_wdata[B_SV_CLR], 1'b0};
  assign hw_set = {tick_evt_i, 2'b00};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sec_pend_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_set (sw_set[i]),
      .sw_clr (sw_clr[i]),
      .hw_set (hw_set[i]),
      .hw_clr (taken_i[i]),
      .flag_q (pend_o[i])
    );
  end

  sec_cfg_regs #(.ADDR_W(ADDR_W), .PRIO_WORDS(PRIO_WORDS), .PRIO_W(PRIO_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_any),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .prio_q     (prio_o),
    .fault_en_q (fault_en_o),
    .vtab_q     (vtab_base_o),
    .rst_req_q  (sys_reset_req_o)
  );

  sec_read_port #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .PRIO_WORDS(PRIO_WORDS)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_any),
    .rd_addr    (reg_addr),
    .act_vec    (act_vec_i),
    .act_valid  (act_valid_i),
    .act_nested (act_nested_i),
    .pend_vec   (pend_vec_i),
    .pend_valid (pend_valid_i),
    .ext_pend   (ext_pend_i),
    .exc_active (exc_active_i),
    .exc_pend   (exc_pend_i),
    .flags      (pend_o),
    .fault_en   (fault_en_o),
    .prio       (prio_o),
    .vtab       (vtab_base_o),
    .rdata_q    (reg_rdata)
  );

  // R2
  nmi_no_sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[0] && !taken_i[0]) |=> pend_o[0]);
  // R4
  tick_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt_i |=> pend_o[2]);
  // R12
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && reg_addr == ADDR_W'(7)) |=> ($stable(prio_o) && $stable(vtab_base_o)
                                            && $stable(fault_en_o)));

endmodule

// File: tb/sec_ctrl_regs_tb.sv
module sec_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_evt_i = 1'b0;
  logic [2:0]  taken_i = '0;
  logic [8:0]  act_vec_i = '0, pend_vec_i = '0;
  logic        act_valid_i = 1'b0, act_nested_i = 1'b0, pend_valid_i = 1'b0, ext_pend_i = 1'b0;
  logic [15:0] exc_active_i = '0, exc_pend_i = '0;
  logic [2:0]  pend_o, fault_en_o;
  logic [95:0] prio_o;
  logic [31:0] vtab_base_o;
  logic        sys_reset_req_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sec_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_evt_i(tick_evt_i),
    .taken_i(taken_i), .act_vec_i(act_vec_i), .act_valid_i(act_valid_i),
    .act_nested_i(act_nested_i), .pend_vec_i(pend_vec_i), .pend_valid_i(pend_valid_i),
    .ext_pend_i(ext_pend_i), .exc_active_i(exc_active_i), .exc_pend_i(exc_pend_i),
    .pend_o(pend_o), .fault_en_o(fault_en_o), .prio_o(prio_o),
    .vtab_base_o(vtab_base_o), .sys_reset_req_o(sys_reset_req_o));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access, held across a single rising edge; returns at the next falling edge
  task automatic access(input logic we, input logic [2:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic pulse(input logic tk, input logic [2:0] tkn);
    tick_evt_i = tk; taken_i = tkn;
    @(posedge clk); @(negedge clk);
    tick_evt_i = 1'b0; taken_i = '0;
  endtask

  // bench's own view of the status word layout
  function automatic logic [31:0] exp_ctl(input logic [8:0] av, input logic avl,
      input logic nst, input logic [8:0] pv, input logic pvl, input logic ex,
      input logic nmi, input logic sv, input logic tk);
    logic [31:0] r;
    r = 32'(avl ? av : 9'd0) + (32'(pvl ? pv : 9'd0) * 32'h1000);
    if (!(avl && nst)) r = r + 32'h800;
    if (ex)  r = r + 32'h0040_0000;
    if (tk)  r = r + 32'h0400_0000;
    if (sv)  r = r + 32'h1000_0000;
    if (nmi) r = r + 32'h8000_0000;
    return r;
  endfunction

  // {we, addr, wdata, expected read}
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h1234_5FFF, 32'h0},          // R7 write
    {1'b0, 3'd1, 32'h0,         32'h1234_5F80},  // R7 read back
    {1'b1, 3'd3, 32'h4433_2211, 32'h0},          // R11
    {1'b0, 3'd3, 32'h0,         32'h4433_2211},  // R11
    {1'b1, 3'd5, 32'hDDCC_BBAA, 32'h0},          // R11
    {1'b0, 3'd5, 32'h0,         32'hDDCC_BBAA},  // R11
    {1'b1, 3'd6, 32'hFFFF_FFFF, 32'h0},          // R10
    {1'b0, 3'd6, 32'h0,         32'h0007_0000},  // R10
    {1'b0, 3'd2, 32'h0,         32'hFA05_0000},  // R8
    {1'b0, 3'd7, 32'h0,         32'h0}           // R12
  };

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pend", 128'(pend_o), 0);
    chk("R1 fault_en", 128'(fault_en_o), 0);
    chk("R1 prio", 128'(prio_o), 0);
    chk("R1 vtab", 128'(vtab_base_o), 0);
    chk("R1 rdata", 128'(reg_rdata), 0);
    chk("R1 rstreq", 128'(sys_reset_req_o), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][67], VEC[i][66:64], VEC[i][63:32]);
      if (!VEC[i][67]) chk($sformatf("table entry %0d", i), 128'(reg_rdata), 128'(VEC[i][31:0]));
    end
    chk("R7 vtab out", 128'(vtab_base_o), 128'(32'h1234_5F80));
    chk("R10 fault_en out", 128'(fault_en_o), 128'(3'b111));
    chk("R11 prio v4", 128'(prio_o[0 +: 8]), 128'(8'h11));
    chk("R11 prio v7", 128'(prio_o[24 +: 8]), 128'(8'h44));
    chk("R11 prio v15", 128'(prio_o[88 +: 8]), 128'(8'hDD));
    chk("R11 prio v8 untouched", 128'(prio_o[32 +: 8]), 0);

    // R12 write to unmapped word changes nothing
    access(1'b1, 3'd7, 32'hFFFF_FFFF);
    chk("R12 unmapped write", 128'({prio_o, vtab_base_o}), 128'({64'h0, 32'hDDCC_BBAA,
          32'h0, 32'h4433_2211, 32'h1234_5F80}));
    access(1'b1, 3'd6, 32'h0002_0000);
    chk("R10 bus only", 128'(fault_en_o), 128'(3'b010));

    // R2 non-maskable flag
    access(1'b1, 3'd0, 32'h8000_0000);
    chk("R2 set", 128'(pend_o[0]), 1);
    access(1'b1, 3'd0, 32'h0);
    chk("R2 zero write keeps", 128'(pend_o[0]), 1);
    pulse(1'b0, 3'b001);
    chk("R2 taken clears", 128'(pend_o[0]), 0);

    // R3 deferred service
    access(1'b1, 3'd0, 32'h1000_0000);
    chk("R3 set", 128'(pend_o[1]), 1);
    access(1'b1, 3'd0, 32'h0800_0000);
    chk("R3 clear", 128'(pend_o[1]), 0);
    access(1'b1, 3'd0, 32'h1800_0000);
    chk("R3 set beats clear", 128'(pend_o[1]), 1);
    pulse(1'b0, 3'b010);
    chk("R3 taken clears", 128'(pend_o[1]), 0);

    // R4 tick
    access(1'b1, 3'd0, 32'h0400_0000);
    chk("R4 set", 128'(pend_o[2]), 1);
    access(1'b1, 3'd0, 32'h0200_0000);
    chk("R4 clear", 128'(pend_o[2]), 0);
    access(1'b1, 3'd0, 32'h0600_0000);
    chk("R4 set beats clear", 128'(pend_o[2]), 1);
    pulse(1'b0, 3'b100);
    chk("R4 taken clears", 128'(pend_o[2]), 0);
    pulse(1'b1, 3'b100);
    chk("R4 event beats taken", 128'(pend_o[2]), 1);

    // R5 / R6 status composition (tick still pending, set nmi too)
    access(1'b1, 3'd0, 32'h8000_0000);
    act_vec_i = 9'd3; act_valid_i = 1'b1; act_nested_i = 1'b1;
    pend_vec_i = 9'd20; pend_valid_i = 1'b1; ext_pend_i = 1'b1;
    access(1'b0, 3'd0, 32'h0);
    chk("R5 full word", 128'(reg_rdata), 128'(exp_ctl(9'd3, 1, 1, 9'd20, 1, 1, 1, 0, 1)));
    act_nested_i = 1'b0; act_vec_i = 9'd300; pend_valid_i = 1'b0; ext_pend_i = 1'b0;
    access(1'b0, 3'd0, 32'h0);
    chk("R6 not nested", 128'(reg_rdata), 128'(exp_ctl(9'd300, 1, 0, 9'd20, 0, 0, 1, 0, 1)));
    act_valid_i = 1'b0; act_nested_i = 1'b1;
    access(1'b0, 3'd0, 32'h0);
    chk("R6 none active", 128'(reg_rdata), 128'(exp_ctl(9'd300, 0, 1, 9'd0, 0, 0, 1, 0, 1)));
    act_valid_i = 1'b1;
    @(negedge clk);
    chk("R12 rdata held", 128'(reg_rdata), 128'(exp_ctl(9'd300, 0, 1, 9'd0, 0, 0, 1, 0, 1)));

    // R9 handler status bit map
    exc_active_i = 16'hFFFF; exc_pend_i = 16'h0000;
    access(1'b0, 3'd6, 32'h0);
    chk("R9 active bits", 128'(reg_rdata), 128'(32'h0002_0D8B));
    exc_active_i = 16'h0000; exc_pend_i = 16'h0870;
    access(1'b0, 3'd6, 32'h0);
    chk("R9 pending bits", 128'(reg_rdata), 128'(32'h0002_F000));

    // R8 keyed reset
    access(1'b1, 3'd2, 32'h05FA_0004);
    chk("R8 pulse high", 128'(sys_reset_req_o), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", 128'(sys_reset_req_o), 0);
    access(1'b1, 3'd2, 32'h05FB_0004);
    chk("R8 wrong key", 128'(sys_reset_req_o), 0);
    access(1'b1, 3'd2, 32'h05FA_0000);
    chk("R8 key without reset bit", 128'(sys_reset_req_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule